// File: doc/BRIEF.md
# Fetch-Address Breakpoint and Trace Trigger Unit

This block sits next to a small processor core and watches two of its buses: the instruction fetch address taken from the program counter, and the data access bus. When a programmed condition is met, it raises a debug-entry request for one cycle. It also presents a 3-bit trigger code that names the cause, so an external logic analyzer can start a capture on it. Because the match is made on the fetch address and not on memory contents, code that stays in a cache is caught without patching memory.

The unit holds several instruction-address comparators, each with its own enable bit. It has one data watch, which matches either a single value or an inclusive range and can be limited to reads, to writes, or to both. A trace option requests a trap after every retired instruction, except while the core is already in debug mode. The configuration registers can be written from a software write port and from an external debug-port write path. When both write in the same cycle, the debug port wins.

Register indices, with `NUM_BP` = 4: indices 0..3 hold the comparator addresses. Index 4 holds the comparator enables in bits [3:0]. Index 5 holds the data low bound, which is also the exact value. Index 6 holds the data high bound. Index 7 is the control register: bit0 enables the data watch, bit1 selects range mode (0 = exact), bit2 matches reads, bit3 matches writes, and bit4 enables trace.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, `dbg_req` is 0 and `trig_code` is 000. All comparators, the data watch and trace are disabled, so a valid fetch of address 0 raises nothing.
- R2: A valid fetch whose address equals an enabled comparator i causes `dbg_req` = 1 and `trig_code` = i+1 (001..100) in the next cycle. Both return to 0/000 the cycle after unless a new hit occurs.
- R3: A fetch raises nothing when `fetch_valid` is low or when the matching comparator's enable bit is clear.
- R4: When several comparators match the same fetch, the lowest-numbered one supplies the code.
- R5: In exact mode (control bit1 = 0), the data watch hits only when the access data equals the low-bound register.
- R6: In range mode (control bit1 = 1), the data watch hits when low <= data <= high, inclusive at both bounds. The data watch code is 101.
- R7: The data watch hits on a read only if control bit2 is set, and on a write (`dacc_write` = 1) only if control bit3 is set.
- R8: With control bit4 set, each cycle with `retire_valid` high produces code 110 in the next cycle.
- R9: While `in_debug` is high, retirements raise no trace request.
- R10: When causes coincide in one cycle, a single request is raised. The code priority is address comparator over data watch over trace.
- R11: A configuration write from either port takes effect. When both ports write in the same cycle, only the debug-port write is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | AW | Program-counter fetch address |
| dacc_valid | input | 1 | Data access strobe |
| dacc_write | input | 1 | 1 = write access, 0 = read access |
| dacc_data | input | DW | Data on the access bus |
| retire_valid | input | 1 | One instruction completed |
| in_debug | input | 1 | Core is executing the debug handler |
| sw_wr_en | input | 1 | Software configuration write strobe |
| sw_addr | input | CAW | Software register index |
| sw_wdata | input | DW | Software write data |
| dp_wr_en | input | 1 | Debug-port configuration write strobe |
| dp_addr | input | CAW | Debug-port register index |
| dp_wdata | input | DW | Debug-port write data |
| dbg_req | output | 1 | One-cycle debug-entry request |
| trig_code | output | CW | Trigger cause code for the analyzer pins |

## Verification
Three functions can fall in the same cycle: an address-comparator hit, a data-watch hit and a trace retirement. The bench drives a matching fetch, an in-range data access and a retirement together, and expects exactly one request carrying the comparator's code. It then drops the fetch while keeping the other two causes, and expects the data-watch code 101. A second overlap comes from the two configuration write ports striking in the same cycle. That case is judged by fetching both written addresses and seeing that only the debug-port value hits.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;

   // Data watch / trace control word, low bits of the control register
   typedef struct packed {
      logic trace_en;    // bit4
      logic match_wr;    // bit3
      logic match_rd;    // bit2
      logic range_mode;  // bit1
      logic watch_en;    // bit0
   } watch_ctrl_t;

   localparam int CTRL_BITS = $bits(watch_ctrl_t);

   // Code for address comparator idx (idle is zero)
   function automatic int bp_code(input int idx);
      return idx + 1;
   endfunction

   function automatic int data_code(input int nbp);
      return nbp + 1;
   endfunction

   function automatic int trace_code(input int nbp);
      return nbp + 2;
   endfunction

endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
   import dbg_watch_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int CAW    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sw_wr_en,
   input  logic [CAW-1:0]               sw_addr,
   input  logic [DW-1:0]                sw_wdata,
   input  logic                         dp_wr_en,
   input  logic [CAW-1:0]               dp_addr,
   input  logic [DW-1:0]                dp_wdata,
   output logic [NUM_BP-1:0][AW-1:0]    bp_addr,
   output logic [NUM_BP-1:0]            bp_en,
   output logic [DW-1:0]                data_lo,
   output logic [DW-1:0]                data_hi,
   output watch_ctrl_t                  ctrl
);

   localparam int IDX_EN   = NUM_BP;
   localparam int IDX_LO   = NUM_BP + 1;
   localparam int IDX_HI   = NUM_BP + 2;
   localparam int IDX_CTRL = NUM_BP + 3;

   // Debug port has priority over the software port
   logic           wr;
   logic [CAW-1:0] widx;
   logic [DW-1:0]  wval;

   always_comb begin
      wr   = dp_wr_en | sw_wr_en;
      widx = dp_wr_en ? dp_addr  : sw_addr;
      wval = dp_wr_en ? dp_wdata : sw_wdata;
   end

   genvar g;
   generate
      for (g = 0; g < NUM_BP; g++) begin : g_bp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bp_addr[g] <= '0;
            else if (wr && (int'(widx) == g))
               bp_addr[g] <= wval[AW-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_en   <= '0;
         data_lo <= '0;
         data_hi <= '0;
         ctrl    <= '0;
      end else if (wr) begin
         if (int'(widx) == IDX_EN)   bp_en   <= wval[NUM_BP-1:0];
         if (int'(widx) == IDX_LO)   data_lo <= wval;
         if (int'(widx) == IDX_HI)   data_hi <= wval;
         if (int'(widx) == IDX_CTRL) ctrl    <= watch_ctrl_t'(wval[CTRL_BITS-1:0]);
      end
   end

endmodule

// File: rtl/dbg_addr_match.sv
module dbg_addr_match #(
   parameter int NUM_BP = 4,
   parameter int AW     = 16
) (
   input  logic                      fetch_valid,
   input  logic [AW-1:0]             fetch_addr,
   input  logic [NUM_BP-1:0][AW-1:0] bp_addr,
   input  logic [NUM_BP-1:0]         bp_en,
   output logic [NUM_BP-1:0]         bp_hit
);

   genvar g;
   generate
      for (g = 0; g < NUM_BP; g++) begin : g_cmp
         assign bp_hit[g] = fetch_valid & bp_en[g] & (fetch_addr == bp_addr[g]);
      end
   endgenerate

endmodule

// File: rtl/dbg_data_watch.sv
module dbg_data_watch
   import dbg_watch_pkg::*;
#(
   parameter int DW       = 16,
   parameter bit RANGE_EN = 1'b1
) (
   input  logic          dacc_valid,
   input  logic          dacc_write,
   input  logic [DW-1:0] dacc_data,
   input  logic [DW-1:0] data_lo,
   input  logic [DW-1:0] data_hi,
   input  watch_ctrl_t   ctrl,
   output logic          data_hit
);

   logic value_ok;
   logic dir_ok;

   generate
      if (RANGE_EN) begin : g_range
         always_comb begin
            if (ctrl.range_mode)
               value_ok = (dacc_data >= data_lo) && (dacc_data <= data_hi);
            else
               value_ok = (dacc_data == data_lo);
         end
      end else begin : g_exact
         assign value_ok = (dacc_data == data_lo);
      end
   endgenerate

   assign dir_ok   = dacc_write ? ctrl.match_wr : ctrl.match_rd;
   assign data_hit = dacc_valid & ctrl.watch_en & dir_ok & value_ok;

endmodule

// File: rtl/dbg_trig_encode.sv
module dbg_trig_encode
   import dbg_watch_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int CW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_BP-1:0] bp_hit,
   input  logic              data_hit,
   input  logic              trace_hit,
   output logic              dbg_req,
   output logic [CW-1:0]     trig_code
);

   logic [CW-1:0] code_nxt;

   // Lowest comparator first, then data watch, then trace
   always_comb begin
      code_nxt = '0;
      if (trace_hit) code_nxt = CW'(trace_code(NUM_BP));
      if (data_hit)  code_nxt = CW'(data_code(NUM_BP));
      for (int i = NUM_BP - 1; i >= 0; i--) begin
         if (bp_hit[i]) code_nxt = CW'(bp_code(i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_code <= '0;
         dbg_req   <= 1'b0;
      end else begin
         trig_code <= code_nxt;
         dbg_req   <= (|bp_hit) | data_hit | trace_hit;
      end
   end

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
   import dbg_watch_pkg::*;
#(
   parameter int NUM_BP   = 4,
   parameter int AW       = 16,
   parameter int DW       = 16,
   parameter int CW       = 3,
   parameter bit RANGE_EN = 1'b1,
   parameter int CAW      = $clog2(NUM_BP + 4)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fetch_valid,
   input  logic [AW-1:0]  fetch_addr,
   input  logic           dacc_valid,
   input  logic           dacc_write,
   input  logic [DW-1:0]  dacc_data,
   input  logic           retire_valid,
   input  logic           in_debug,
   input  logic           sw_wr_en,
   input  logic [CAW-1:0] sw_addr,
   input  logic [DW-1:0]  sw_wdata,
   input  logic           dp_wr_en,
   input  logic [CAW-1:0] dp_addr,
   input  logic [DW-1:0]  dp_wdata,
   output logic           dbg_req,
   output logic [CW-1:0]  trig_code
);

   generate
      if (NUM_BP < 1) begin : g_chk_nbp
         $error("NUM_BP must be at least 1");
      end
      if (trace_code(NUM_BP) >= (1 << CW)) begin : g_chk_cw
         $error("CW too narrow for NUM_BP comparator codes");
      end
      if (AW > DW) begin : g_chk_aw
         $error("AW must not exceed DW");
      end
      if (DW < NUM_BP || DW < CTRL_BITS) begin : g_chk_dw
         $error("DW too narrow for enable or control word");
      end
   endgenerate

   logic [NUM_BP-1:0][AW-1:0] bp_addr;
   logic [NUM_BP-1:0]         bp_en;
   logic [DW-1:0]             data_lo;
   logic [DW-1:0]             data_hi;
   watch_ctrl_t               ctrl;
   logic [NUM_BP-1:0]         bp_hit;
   logic                      data_hit;
   logic                      trace_hit;
   logic                      trace_on;

   dbg_cfg_regs #(.NUM_BP(NUM_BP), .AW(AW), .DW(DW), .CAW(CAW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_wr_en (sw_wr_en),
      .sw_addr  (sw_addr),
      .sw_wdata (sw_wdata),
      .dp_wr_en (dp_wr_en),
      .dp_addr  (dp_addr),
      .dp_wdata (dp_wdata),
      .bp_addr  (bp_addr),
      .bp_en    (bp_en),
      .data_lo  (data_lo),
      .data_hi  (data_hi),
      .ctrl     (ctrl)
   );

   dbg_addr_match #(.NUM_BP(NUM_BP), .AW(AW)) u_amatch (
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .bp_addr     (bp_addr),
      .bp_en       (bp_en),
      .bp_hit      (bp_hit)
   );

   dbg_data_watch #(.DW(DW), .RANGE_EN(RANGE_EN)) u_dwatch (
      .dacc_valid (dacc_valid),
      .dacc_write (dacc_write),
      .dacc_data  (dacc_data),
      .data_lo    (data_lo),
      .data_hi    (data_hi),
      .ctrl       (ctrl),
      .data_hit   (data_hit)
   );

   assign trace_on  = ctrl.trace_en;
   assign trace_hit = retire_valid & trace_on & ~in_debug;

   dbg_trig_encode #(.NUM_BP(NUM_BP), .CW(CW)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .bp_hit    (bp_hit),
      .data_hit  (data_hit),
      .trace_hit (trace_hit),
      .dbg_req   (dbg_req),
      .trig_code (trig_code)
   );

endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk #(
   parameter int NUM_BP = 4,
   parameter int CW     = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_valid,
   input logic          dacc_valid,
   input logic          retire_valid,
   input logic          in_debug,
   input logic          trace_on,
   input logic          dbg_req,
   input logic [CW-1:0] trig_code
);

   // R10: one request, always paired with a nonzero cause code
   assert_req_has_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req == (trig_code != '0));

   // R2: only defined cause codes appear
   assert_code_defined_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(trig_code) <= NUM_BP + 2);

   // R3: no activity on any watched bus gives no request
   assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && !dacc_valid && !retire_valid) |=> !dbg_req);

   // R9: retirement inside the debug handler alone never traps
   assert_no_self_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && in_debug && !fetch_valid && !dacc_valid) |=> !dbg_req);

   // R8: a lone retirement with trace on gives the trace code
   assert_trace_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && trace_on && !in_debug && !fetch_valid && !dacc_valid)
      |=> (int'(trig_code) == NUM_BP + 2));

endmodule

bind dbg_watch_unit dbg_watch_chk #(.NUM_BP(NUM_BP), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_valid  (fetch_valid),
   .dacc_valid   (dacc_valid),
   .retire_valid (retire_valid),
   .in_debug     (in_debug),
   .trace_on     (trace_on),
   .dbg_req      (dbg_req),
   .trig_code    (trig_code)
);

// File: tb/dbg_watch_unit_test.sv
module dbg_watch_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int CW  = 3;
   localparam int CAW = 3;
   localparam int WATCHDOG = 20000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fetch_valid = 1'b0;
   logic [AW-1:0]  fetch_addr = '0;
   logic           dacc_valid = 1'b0;
   logic           dacc_write = 1'b0;
   logic [DW-1:0]  dacc_data = '0;
   logic           retire_valid = 1'b0;
   logic           in_debug = 1'b0;
   logic           sw_wr_en = 1'b0;
   logic [CAW-1:0] sw_addr = '0;
   logic [DW-1:0]  sw_wdata = '0;
   logic           dp_wr_en = 1'b0;
   logic [CAW-1:0] dp_addr = '0;
   logic [DW-1:0]  dp_wdata = '0;
   logic           dbg_req;
   logic [CW-1:0]  trig_code;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   int    q_code[$];
   string q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_watch_unit uut (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .dacc_valid(dacc_valid), .dacc_write(dacc_write), .dacc_data(dacc_data),
      .retire_valid(retire_valid), .in_debug(in_debug),
      .sw_wr_en(sw_wr_en), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
      .dp_wr_en(dp_wr_en), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
      .dbg_req(dbg_req), .trig_code(trig_code)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: result of the previous cycle's inputs, just after the edge
   always @(posedge clk) begin
      #1;
      if (q_code.size() > 0) begin
         int    e;
         string t;
         e = q_code.pop_front();
         t = q_tag.pop_front();
         check({t, " code"}, int'(trig_code), e);
         check({t, " req"}, int'(dbg_req), (e != 0) ? 1 : 0);
      end
   end

   // Driver: one cycle of bus stimulus and the expected code after it
   task automatic drive(input bit fv, input int fa, input bit dv, input bit dw,
                        input int dd, input bit rv, input bit dbg,
                        input int exp, input string tag);
      @(negedge clk);
      sw_wr_en     = 1'b0;
      dp_wr_en     = 1'b0;
      fetch_valid  = fv;
      fetch_addr   = AW'(fa);
      dacc_valid   = dv;
      dacc_write   = dw;
      dacc_data    = DW'(dd);
      retire_valid = rv;
      in_debug     = dbg;
      q_code.push_back(exp);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input string tag);
      drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic cfg(input bit use_dp, input int idx, input int val, input string tag);
      @(negedge clk);
      fetch_valid  = 1'b0;
      dacc_valid   = 1'b0;
      retire_valid = 1'b0;
      sw_wr_en     = !use_dp;
      dp_wr_en     = use_dp;
      sw_addr      = CAW'(idx);
      dp_addr      = CAW'(idx);
      sw_wdata     = DW'(val);
      dp_wdata     = DW'(val);
      q_code.push_back(0);
      q_tag.push_back(tag);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= WATCHDOG && !done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset code", int'(trig_code), 0);
      check("R1 reset req", int'(dbg_req), 0);
      rst_n = 1'b1;
      drive(1, 'h0, 0, 0, 0, 0, 0, 0, "R1 fetch addr 0 with defaults");
      drive(0, 0, 1, 0, 0, 1, 0, 0, "R1 data/trace off after reset");

      // Comparators: 0x100, 0x200, 0x300, duplicate 0x100 in slot 3
      cfg(0, 0, 'h100, "cfg");
      cfg(0, 1, 'h200, "cfg");
      cfg(0, 2, 'h300, "cfg");
      cfg(0, 3, 'h100, "cfg");
      idle("R3 enables still clear");
      drive(1, 'h200, 0, 0, 0, 0, 0, 0, "R3 disabled comparator");
      cfg(0, 4, 'hF, "cfg");
      drive(1, 'h100, 0, 0, 0, 0, 0, 1, "R4 slot0 beats slot3");
      idle("R2 one-cycle pulse");
      drive(1, 'h200, 0, 0, 0, 0, 0, 2, "R2 comparator1");
      drive(1, 'h300, 0, 0, 0, 0, 0, 3, "R2 comparator2 back-to-back");
      drive(1, 'h301, 0, 0, 0, 0, 0, 0, "R2 near miss");
      drive(0, 'h200, 0, 0, 0, 0, 0, 0, "R3 fetch_valid low");
      cfg(0, 4, 'hD, "cfg");
      drive(1, 'h200, 0, 0, 0, 0, 0, 0, "R3 comparator1 disabled");
      drive(1, 'h100, 0, 0, 0, 0, 0, 1, "R3 others still enabled");
      cfg(1, 3, 'h400, "cfg");
      cfg(1, 4, 'hF, "cfg");
      drive(1, 'h400, 0, 0, 0, 0, 0, 4, "R11 debug-port write, comparator3");

      // Data watch exact
      cfg(0, 5, 'h10, "cfg");
      cfg(0, 6, 'h20, "cfg");
      cfg(0, 7, 'h0D, "cfg");
      drive(0, 0, 1, 0, 'h10, 0, 0, 5, "R5 exact match");
      drive(0, 0, 1, 0, 'h11, 0, 0, 0, "R5 exact ignores range");
      // Range
      cfg(0, 7, 'h0F, "cfg");
      drive(0, 0, 1, 0, 'h10, 0, 0, 5, "R6 low bound");
      drive(0, 0, 1, 1, 'h20, 0, 0, 5, "R6 high bound");
      drive(0, 0, 1, 0, 'h21, 0, 0, 0, "R6 above high");
      drive(0, 0, 1, 0, 'h0F, 0, 0, 0, "R6 below low");
      drive(0, 0, 0, 0, 'h15, 0, 0, 0, "R6 valid low");
      // Direction
      cfg(0, 7, 'h07, "cfg");
      drive(0, 0, 1, 1, 'h15, 0, 0, 0, "R7 reads only, write");
      drive(0, 0, 1, 0, 'h15, 0, 0, 5, "R7 reads only, read");
      cfg(0, 7, 'h0B, "cfg");
      drive(0, 0, 1, 1, 'h15, 0, 0, 5, "R7 writes only, write");
      drive(0, 0, 1, 0, 'h15, 0, 0, 0, "R7 writes only, read");

      // Trace
      cfg(0, 7, 'h10, "cfg");
      drive(0, 0, 1, 0, 'h15, 0, 0, 0, "R8 data watch now off");
      drive(0, 0, 0, 0, 0, 1, 0, 6, "R8 trace step");
      drive(0, 0, 0, 0, 0, 1, 0, 6, "R8 trace consecutive");
      drive(0, 0, 0, 0, 0, 1, 1, 0, "R9 in debug");
      drive(0, 0, 0, 0, 0, 0, 0, 0, "R8 no retire");

      // Coincident causes
      cfg(0, 7, 'h1F, "cfg");
      drive(1, 'h100, 1, 0, 'h15, 1, 0, 1, "R10 all three");
      drive(0, 0, 1, 0, 'h15, 1, 0, 5, "R10 data over trace");
      drive(1, 'h300, 0, 0, 0, 1, 0, 3, "R10 address over trace");

      // Both write ports in the same cycle
      @(negedge clk);
      fetch_valid = 1'b0; dacc_valid = 1'b0; retire_valid = 1'b0;
      sw_wr_en = 1'b1; sw_addr = 3'd0; sw_wdata = 'h500;
      dp_wr_en = 1'b1; dp_addr = 3'd0; dp_wdata = 'h600;
      q_code.push_back(0); q_tag.push_back("cfg both");
      drive(1, 'h600, 0, 0, 0, 0, 0, 1, "R11 debug-port value applied");
      drive(1, 'h500, 0, 0, 0, 0, 0, 0, "R11 software value dropped");
      idle("tail");
      idle("tail");

      while (q_code.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule